// File: doc/BRIEF.md
# Synthesizer Register Word Sequencer

This block drives the configuration port of a direct digital synthesis generator that has a 28-bit frequency accumulator and a 12-bit phase offset. It takes three live selections: a waveform choice, a precomputed 28-bit tuning word and a precomputed 12-bit phase word. From them it produces the five 16-bit register words that set the generator up. The words leave on a valid/ready stream with a last flag, and a serial writer downstream shifts them out.

A sequence starts when any selection differs from the value it had on the previous clock, or when a start pulse arrives. The words always come in this order:

1. A mode word that arms a full-width frequency load.
2. The low fourteen tuning bits.
3. The high fourteen tuning bits.
4. The phase word.
5. The waveform control word.

If a selection changes or a start arrives while a sequence is in flight, the block remembers it. One further sequence follows after the current one ends, and it carries the newest selections. Sequences never interleave, and any number of updates made during one sequence are merged into that single follow-up.

Top module: `dds_cfg_sequencer`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) m_valid_o and done_o are low, and the stored previous selection is waveform 0, tuning word 0, phase word 0.
- R2: A sequence is launched at the first rising edge at which start_i is high, or at which wave_sel_i, freq_word_i or phase_word_i differs from its value at the previous edge. The first word is valid right after that edge.
- R3: The first word of every sequence is 0x2000.
- R4: The second word is 0x4000 OR tuning bits [13:0]. For example, 0x20C49 gives 0x4C49 and 0x10624 gives 0x4624.
- R5: The third word is 0x4000 OR tuning bits [27:14]. For example, 0x20C49 gives 0x4008 and 0x10624 gives 0x4004.
- R6: The fourth word is 0xD000 OR the 12-bit phase word. For example, phase 0x000 gives 0xD000 and 0x800 gives 0xD800.
- R7: The fifth word is the waveform control word. Encoding 2'b00 gives 0x0008 (sine), 2'b01 gives 0x000A (triangle), 2'b10 gives 0x0028 (square), and the unused code 2'b11 gives 0x0008.
- R8: m_last_o is high only with the fifth word. done_o is high for exactly the one cycle in which the fifth word is accepted (valid and ready both high).
- R9: While m_valid_o is high and m_ready_i is low, m_valid_o, m_data_o and m_last_o hold their values into the next cycle.
- R10: Triggers that arrive while a sequence is in progress, including in the cycle its last word is accepted, cause exactly one further sequence. That sequence starts one idle cycle after the current one ends and uses the selections present at its launch edge.
- R11: While start_i is low and the selections are unchanged, no word is emitted.
- R12: The selections of a sequence are captured at its launch edge. Changes made while it is in flight do not alter its remaining words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one sequence with the current selections |
| wave_sel_i | input | 2 | Waveform choice: 00 sine, 01 triangle, 10 square, 11 sine |
| freq_word_i | input | 28 | Precomputed frequency tuning word |
| phase_word_i | input | 12 | Precomputed phase offset word |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Downstream writer accepts the word |
| m_data_o | output | 16 | Register word |
| m_last_o | output | 1 | Final word of a sequence |
| done_o | output | 1 | One-cycle pulse when the final word is accepted |

## Verification
The case that needs the most care is a new trigger (a selection change or a start pulse) landing in the same cycle as acceptance of the last word. In that cycle the block has to record the request and release the stream at once. The bench provokes this by polling until the last word is presented with ready high, then changing a selection before that edge, and by also doing it under random back-pressure. It judges the result with a behavioural queue model, compared on every clock, which expects the old sequence to end intact, one idle cycle to follow, and then exactly one new sequence that carries the newest values.

// File: rtl/dds_seq_pkg.sv
// Package: shared widths, word constants and enums for the configuration
// sequencer. Assumes a generator with a 28-bit tuning register written in
// two 14-bit halves and a 12-bit phase register.
package dds_seq_pkg;

    localparam int FREQ_BITS  = 28;
    localparam int PHASE_BITS = 12;
    localparam int WAVE_BITS  = 2;
    localparam int WORD_BITS  = 16;
    localparam int SEQ_WORDS  = 5;

    // Waveform select encodings
    typedef enum logic [WAVE_BITS-1:0] {
        WAVE_SINE   = 2'b00,
        WAVE_TRI    = 2'b01,
        WAVE_SQUARE = 2'b10,
        WAVE_SPARE  = 2'b11
    } wave_sel_e;

    // Order of words inside one sequence (order is behaviour)
    typedef enum logic [2:0] {
        SLOT_MODE  = 3'd0,
        SLOT_F_LO  = 3'd1,
        SLOT_F_HI  = 3'd2,
        SLOT_PHASE = 3'd3,
        SLOT_WAVE  = 3'd4
    } slot_e;

    localparam logic [WORD_BITS-1:0] MODE_FULL_LOAD = 16'h2000;
    localparam logic [WORD_BITS-1:0] CTRL_SINE      = 16'h0008;
    localparam logic [WORD_BITS-1:0] CTRL_TRI       = 16'h000A;
    localparam logic [WORD_BITS-1:0] CTRL_SQUARE    = 16'h0028;
    localparam logic [1:0]           FREQ0_TAG      = 2'b01;
    localparam logic [3:0]           PHASE0_TAG     = 4'hD;

endpackage

// File: rtl/dds_sel_tracker.sv
// Selection tracker: remembers last-cycle selections, turns changes and
// start pulses into a sticky request, and launches a sequence whenever the
// emitter is idle, capturing the selections used for that sequence.
// Assumes busy_i is high from the edge after launch until the last word
// is accepted.
module dds_sel_tracker #(
    parameter int FREQ_W  = dds_seq_pkg::FREQ_BITS,
    parameter int PHASE_W = dds_seq_pkg::PHASE_BITS,
    parameter int WAVE_W  = dds_seq_pkg::WAVE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WAVE_W-1:0]  wave_i,
    input  logic [FREQ_W-1:0]  freq_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               busy_i,
    output logic               launch_o,
    output logic [WAVE_W-1:0]  snap_wave_o,
    output logic [FREQ_W-1:0]  snap_freq_o,
    output logic [PHASE_W-1:0] snap_phase_o
);

    logic [WAVE_W-1:0]  prev_wave_q;
    logic [FREQ_W-1:0]  prev_freq_q;
    logic [PHASE_W-1:0] prev_phase_q;
    logic               pending_q;
    logic               changed;
    logic               request;

    // Detect any selection difference against the previous cycle
    always_comb begin
        changed = (wave_i != prev_wave_q) || (freq_i != prev_freq_q) ||
                  (phase_i != prev_phase_q);
        request = changed || start_i;
    end

    // Launch when idle and a request is new or waiting
    always_comb begin
        launch_o = !busy_i && (pending_q || request);
    end

    // Keep a copy of last-cycle selections for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wave_q  <= '0;
            prev_freq_q  <= '0;
            prev_phase_q <= '0;
        end else begin
            prev_wave_q  <= wave_i;
            prev_freq_q  <= freq_i;
            prev_phase_q <= phase_i;
        end
    end

    // Sticky request: holds triggers that arrive while a sequence runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= (pending_q || request) && !launch_o;
        end
    end

    // Capture the selections a sequence will carry at its launch edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_wave_o  <= '0;
            snap_freq_o  <= '0;
            snap_phase_o <= '0;
        end else if (launch_o) begin
            snap_wave_o  <= wave_i;
            snap_freq_o  <= freq_i;
            snap_phase_o <= phase_i;
        end
    end

    // R10
    pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && busy_i) |=> pending_q)
        else $error("pending request dropped while busy");

endmodule

// File: rtl/dds_word_builder.sv
// Word builder: combinational mapping from a captured selection and a
// slot index to one 16-bit register word. Assumes the tuning word splits
// into two equal halves whose width plus the two-bit register tag fills
// one word.
module dds_word_builder #(
    parameter int FREQ_W  = dds_seq_pkg::FREQ_BITS,
    parameter int PHASE_W = dds_seq_pkg::PHASE_BITS,
    parameter int WAVE_W  = dds_seq_pkg::WAVE_BITS,
    parameter int WORD_W  = dds_seq_pkg::WORD_BITS
) (
    input  logic [WAVE_W-1:0]  wave_i,
    input  logic [FREQ_W-1:0]  freq_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [2:0]         slot_i,
    output logic [WORD_W-1:0]  word_o
);
    import dds_seq_pkg::*;

    localparam int HALF_W  = FREQ_W / 2;
    localparam int N_HALF  = 2;
    localparam int PTAG_W  = WORD_W - PHASE_W;

    logic [WORD_W-1:0] half_word [N_HALF];
    logic [WORD_W-1:0] phase_word;
    logic [WORD_W-1:0] wave_word;

    // Tag each tuning half with the frequency-register prefix
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        always_comb begin
            half_word[h] = {FREQ0_TAG, freq_i[h*HALF_W +: HALF_W]};
        end
    end

    // Tag the phase word with the phase-register prefix
    always_comb begin
        phase_word = {PHASE0_TAG[PTAG_W-1:0], phase_i};
    end

    // Map the waveform code to its control word, spare code to sine
    always_comb begin
        case (wave_sel_e'(wave_i))
            WAVE_TRI:    wave_word = CTRL_TRI;
            WAVE_SQUARE: wave_word = CTRL_SQUARE;
            default:     wave_word = CTRL_SINE;
        endcase
    end

    // Select the word for the current slot
    always_comb begin
        case (slot_e'(slot_i))
            SLOT_MODE:  word_o = MODE_FULL_LOAD;
            SLOT_F_LO:  word_o = half_word[0];
            SLOT_F_HI:  word_o = half_word[1];
            SLOT_PHASE: word_o = phase_word;
            default:    word_o = wave_word;
        endcase
    end

endmodule

// File: rtl/dds_seq_emitter.sv
// Stream emitter: walks the slot index through one sequence, presents
// valid/last, and advances only on accepted words. Assumes launch_i is
// raised only while busy_o is low.
module dds_seq_emitter #(
    parameter int N_WORDS = dds_seq_pkg::SEQ_WORDS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch_i,
    input  logic       ready_i,
    output logic       busy_o,
    output logic [2:0] slot_o,
    output logic       valid_o,
    output logic       last_o,
    output logic       done_o
);

    localparam logic [2:0] FINAL_SLOT = 3'(N_WORDS - 1);

    logic       busy_q;
    logic [2:0] slot_q;
    logic       accept;

    // Stream handshake and end-of-sequence flags
    always_comb begin
        valid_o = busy_q;
        last_o  = busy_q && (slot_q == FINAL_SLOT);
        accept  = busy_q && ready_i;
        done_o  = accept && last_o;
        busy_o  = busy_q;
        slot_o  = slot_q;
    end

    // Sequence progress: start at slot zero, step on each accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            slot_q <= '0;
        end else if (launch_i) begin
            busy_q <= 1'b1;
            slot_q <= '0;
        end else if (accept) begin
            if (slot_q == FINAL_SLOT) begin
                busy_q <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + 3'd1;
            end
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done held for more than one cycle");

endmodule

// File: rtl/dds_cfg_sequencer.sv
// Top: turns waveform, tuning and phase selections into the ordered
// register-word stream for a synthesis generator. Assumes the downstream
// writer follows valid/ready rules and the tuning/phase words arrive
// precomputed.
module dds_cfg_sequencer #(
    parameter int FREQ_W  = dds_seq_pkg::FREQ_BITS,
    parameter int PHASE_W = dds_seq_pkg::PHASE_BITS,
    parameter int WAVE_W  = dds_seq_pkg::WAVE_BITS,
    parameter int WORD_W  = dds_seq_pkg::WORD_BITS,
    parameter int N_WORDS = dds_seq_pkg::SEQ_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WAVE_W-1:0]  wave_sel_i,
    input  logic [FREQ_W-1:0]  freq_word_i,
    input  logic [PHASE_W-1:0] phase_word_i,
    output logic               m_valid_o,
    input  logic               m_ready_i,
    output logic [WORD_W-1:0]  m_data_o,
    output logic               m_last_o,
    output logic               done_o
);
    import dds_seq_pkg::*;

    logic               launch;
    logic               busy;
    logic [2:0]         slot;
    logic [WAVE_W-1:0]  snap_wave;
    logic [FREQ_W-1:0]  snap_freq;
    logic [PHASE_W-1:0] snap_phase;

    dds_sel_tracker #(
        .FREQ_W (FREQ_W),
        .PHASE_W(PHASE_W),
        .WAVE_W (WAVE_W)
    ) i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .wave_i      (wave_sel_i),
        .freq_i      (freq_word_i),
        .phase_i     (phase_word_i),
        .busy_i      (busy),
        .launch_o    (launch),
        .snap_wave_o (snap_wave),
        .snap_freq_o (snap_freq),
        .snap_phase_o(snap_phase)
    );

    dds_seq_emitter #(
        .N_WORDS(N_WORDS)
    ) i_emitter (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .ready_i (m_ready_i),
        .busy_o  (busy),
        .slot_o  (slot),
        .valid_o (m_valid_o),
        .last_o  (m_last_o),
        .done_o  (done_o)
    );

    dds_word_builder #(
        .FREQ_W (FREQ_W),
        .PHASE_W(PHASE_W),
        .WAVE_W (WAVE_W),
        .WORD_W (WORD_W)
    ) i_builder (
        .wave_i (snap_wave),
        .freq_i (snap_freq),
        .phase_i(snap_phase),
        .slot_i (slot),
        .word_o (m_data_o)
    );

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && !m_ready_i) |=>
            (m_valid_o && $stable(m_data_o) && $stable(m_last_o)))
        else $error("stream word changed under back-pressure");

    // R3
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid_o) |-> (m_data_o == MODE_FULL_LOAD))
        else $error("sequence did not open with the mode word");

    // R4
    freq_follows_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && m_ready_i && m_data_o == MODE_FULL_LOAD) |=>
            (m_valid_o && m_data_o[WORD_W-1 -: 2] == FREQ0_TAG))
        else $error("mode word not followed by a frequency word");

    // R7
    last_is_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_last_o |-> (m_data_o == CTRL_SINE || m_data_o == CTRL_TRI ||
                      m_data_o == CTRL_SQUARE))
        else $error("final word is not a waveform control word");

endmodule

// File: tb/test_dds_cfg_sequencer.sv
module test_dds_cfg_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  wave_sel_i = 2'b00;
    logic [27:0] freq_word_i = '0;
    logic [11:0] phase_word_i = '0;
    logic        m_ready_i = 1'b1;
    logic        m_valid_o;
    logic [15:0] m_data_o;
    logic        m_last_o;
    logic        done_o;

    int          errors = 0;
    int          checks = 0;
    int          cycle = 0;
    bit          rand_ready = 1'b0;
    bit          finished = 1'b0;

    // Reference model state
    logic [15:0] exp_q[$];
    logic [15:0] log_q[$];
    bit          m_pend = 1'b0;
    logic [1:0]  m_pw = '0;
    logic [27:0] m_pf = '0;
    logic [11:0] m_pp = '0;
    bit          prev_ready = 1'b1;

    always #5 clk = ~clk;

    dds_cfg_sequencer i_dds_cfg_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .wave_sel_i  (wave_sel_i),
        .freq_word_i (freq_word_i),
        .phase_word_i(phase_word_i),
        .m_valid_o   (m_valid_o),
        .m_ready_i   (m_ready_i),
        .m_data_o    (m_data_o),
        .m_last_o    (m_last_o),
        .done_o      (done_o)
    );

    function automatic logic [15:0] wave_word(input logic [1:0] w);
        if (w == 2'd1) return 16'h000A;
        if (w == 2'd2) return 16'h0028;
        return 16'h0008;
    endfunction

    function automatic logic [15:0] seq_word(input int k, input logic [1:0] w,
                                             input logic [27:0] f, input logic [11:0] p);
        case (k)
            0: return 16'h2000;
            1: return 16'h4000 | {2'b00, f[13:0]};
            2: return 16'h4000 | {2'b00, f[27:14]};
            3: return 16'hD000 | {4'h0, p};
            default: return wave_word(w);
        endcase
    endfunction

    task automatic fail(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) fail(req, what, act, exp);
    endtask

    // Reference model: behavioural queue updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_pend = 1'b0;
            m_pw = '0; m_pf = '0; m_pp = '0;
        end else begin
            bit req, launch;
            req = start_i || (wave_sel_i != m_pw) || (freq_word_i != m_pf) ||
                  (phase_word_i != m_pp);
            launch = (exp_q.size() == 0) && (m_pend || req);
            if (m_valid_o && m_ready_i) log_q.push_back(m_data_o);
            if (exp_q.size() > 0 && m_ready_i) void'(exp_q.pop_front());
            if (launch) begin
                for (int k = 0; k < 5; k++)
                    exp_q.push_back(seq_word(k, wave_sel_i, freq_word_i, phase_word_i));
                m_pend = 1'b0;
            end else begin
                m_pend = m_pend || req;
            end
            m_pw = wave_sel_i; m_pf = freq_word_i; m_pp = phase_word_i;
        end
        prev_ready = m_ready_i;
    end

    // Random back-pressure driver
    always @(negedge clk) begin
        if (rand_ready) m_ready_i <= ($urandom_range(0, 2) != 0);
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            int pos;
            string tag;
            pos = 5 - exp_q.size();
            chk("R2", "valid", m_valid_o, exp_q.size() > 0);
            if (exp_q.size() > 0 && m_valid_o) begin
                case (pos)
                    0: tag = "R3";
                    1: tag = "R4";
                    2: tag = "R5";
                    3: tag = "R6";
                    default: tag = "R7";
                endcase
                if (!prev_ready) tag = "R9";
                chk(tag, "data", m_data_o, exp_q[0]);
                chk("R8", "last", m_last_o, exp_q.size() == 1);
            end
            chk("R8", "done", done_o, (exp_q.size() == 1) && m_ready_i);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycle++;
        if (cycle > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycle);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_sel(input logic [1:0] w, input logic [27:0] f, input logic [11:0] p);
        @(negedge clk);
        wave_sel_i = w; freq_word_i = f; phase_word_i = p;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((exp_q.size() != 0 || m_pend) && n < 2000);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_seq(input string req, input logic [1:0] w,
                              input logic [27:0] f, input logic [11:0] p);
        for (int k = 0; k < 5; k++) begin
            logic [15:0] got;
            got = (log_q.size() > 0) ? log_q.pop_front() : 16'hxxxx;
            chk(req, "logged word", got, seq_word(k, w, f, p));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "valid after reset", m_valid_o, 1'b0);
        chk("R1", "done after reset", done_o, 1'b0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R11: zero inputs match stored reset selection, nothing emitted
        chk("R11", "idle words", log_q.size(), 0);

        // R2, R4, R5: 10 kHz sine, phase 0
        set_sel(2'd0, 28'h20C49, 12'h000);
        wait_idle();
        expect_seq("R2", 2'd0, 28'h20C49, 12'h000);
        chk("R4", "low half literal", seq_word(1, 2'd0, 28'h20C49, 0), 16'h4C49);

        // R7: triangle
        set_sel(2'd1, 28'h20C49, 12'h000);
        wait_idle();
        expect_seq("R7", 2'd1, 28'h20C49, 12'h000);

        // R6, R5: 5 kHz square with 180 degrees
        set_sel(2'd2, 28'h10624, 12'h800);
        wait_idle();
        expect_seq("R6", 2'd2, 28'h10624, 12'h800);
        chk("R5", "high half literal", seq_word(2, 2'd2, 28'h10624, 12'h800), 16'h4004);

        // R7: spare code maps to sine
        set_sel(2'd3, 28'h10624, 12'h800);
        wait_idle();
        expect_seq("R7", 2'd3, 28'h10624, 12'h800);

        // R2: start pulse alone
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_idle();
        expect_seq("R2", 2'd3, 28'h10624, 12'h800);

        // R11: steady inputs give no words
        repeat (20) @(negedge clk);
        chk("R11", "steady words", log_q.size(), 0);

        // R10, R12: updates mid-sequence under back-pressure coalesce
        rand_ready = 1'b1;
        set_sel(2'd0, 28'hABCDEF1, 12'h123);
        repeat (3) @(negedge clk);
        wave_sel_i = 2'd1; freq_word_i = 28'h5555555;
        @(negedge clk);
        phase_word_i = 12'hFFF;
        wait_idle();
        expect_seq("R12", 2'd0, 28'hABCDEF1, 12'h123);
        expect_seq("R10", 2'd1, 28'h5555555, 12'hFFF);
        chk("R10", "extra words", log_q.size(), 0);

        // R10: change in the same cycle the last word is accepted
        rand_ready = 1'b0;
        @(negedge clk); m_ready_i = 1'b1;
        set_sel(2'd2, 28'h0000001, 12'h001);
        do begin @(negedge clk); #2; end while (!(m_last_o && m_valid_o));
        freq_word_i = 28'hFFFFFFF;
        wait_idle();
        expect_seq("R10", 2'd2, 28'h0000001, 12'h001);
        expect_seq("R10", 2'd2, 28'hFFFFFFF, 12'h001);

        // R10: start during last-word acceptance under random ready
        rand_ready = 1'b1;
        for (int t = 0; t < 6; t++) begin
            set_sel(2'(t), 28'(t * 28'h0123457), 12'(t * 97));
            do begin @(negedge clk); #2; end while (!(m_last_o && m_ready_i));
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            wait_idle();
            expect_seq("R10", 2'(t), 28'(t * 28'h0123457), 12'(t * 97));
            expect_seq("R10", 2'(t), 28'(t * 28'h0123457), 12'(t * 97));
        end
        rand_ready = 1'b0;

        // R1: reset mid-sequence clears the stream
        set_sel(2'd1, 28'h0F0F0F0, 12'h0F0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R1", "valid in reset", m_valid_o, 1'b0);
        log_q.delete();
        wave_sel_i = 2'd0; freq_word_i = '0; phase_word_i = '0;
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "words after reset", log_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule